// File: doc/BRIEF.md
# Power-management event and control register block

This block is the fixed-function power-management core of a chipset south side. It holds an event status word, an event enable word, a control word and a free-running power-management timer, all behind a 64-byte register window. Software reaches the registers with 16-bit writes and reads, and reads the timer as a 32-bit word. The block raises a level-sensitive system control interrupt (SCI) whenever an enabled event is pending. It also merges in one general-purpose event request supplied by a neighbouring block.

Writing the control word with its sleep-enable bit set starts a sleep action at once. One sleep type asks for a soft power-off. Another asks for a reset and a suspend-to-RAM indication, and marks wake and power-button status so that software sees a resume cause. Firmware can use an APM command strobe to switch the SCI-enable control bit on and off. The timer advances on a one-cycle tick input that stands in for the slow timer clock. Timer status sets each time the count reaches a half-range boundary that is armed ahead of the count.

Top module: `pm1_block`

## Requirements
- R1: The timer is a CNT_W-bit (default 24) up-counter. It increments by one in each cycle where `tick_en` is high, wraps to 0 after all ones, and holds otherwise. A read at offset 0x08 returns the count zero-extended to 32 bits.
- R2: Timer status (status bit 0) sets when an increment makes the count equal to the armed overflow point. After reset the point is 2^(CNT_W-1). When a status write clears a timer status bit that was set, the point is re-armed to (count + 2^(CNT_W-1)) with the low CNT_W-1 bits cleared. That point is also compared in the same cycle, so a tick that lands on it keeps the status set.
- R3: Status sits at offset 0x00. Writing 1 to a status bit clears it and writing 0 leaves it unchanged. An event that sets a bit in the same cycle as a write that clears it wins, and the bit stays set.
- R4: `sci` is high while status AND enable is non-zero in any of bits 0 (timer), 5 (global lock), 8 (power button) or 10 (RTC), or while `gpe_hit` is high. It is low otherwise.
- R5: The enable word at offset 0x02 stores all 16 written bits and reads them back.
- R6: The control word at offset 0x04 stores every written bit except bit 13 (sleep enable), which always reads 0.
- R7: A control write with bit 13 set and sleep type (bits 12:10) equal to 0 makes `poweroff_req` high for exactly the following cycle.
- R8: A control write with bit 13 set and sleep type 1 sets status bits 15 (wake) and 8 (power button). It makes `reset_req` and `suspend_pulse` high for exactly the following cycle. Any other sleep type produces no pulse and sets no status bit.
- R9: Reads at any offset other than 0x00, 0x02, 0x04 or 0x08 return 0. Writes to any other offset, including 0x08, change no register.
- R10: An APM strobe with value 0xF1 sets control bit 0 (SCI enable), and one with value 0xF0 clears it. Any other value leaves the bit unchanged. The APM command decides bit 0 over a control write in the same cycle.
- R11: `pwrbtn_evt` sets status bit 8 only while enable bit 8 is set.
- R12: After reset, status, enable, control and timer all read 0, `sci` is low (with `gpe_hit` low) and no request pulse is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | One-cycle timer advance strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 6 | Byte offset in the register window |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| pwrbtn_evt | input | 1 | Power-button event pulse |
| apm_wr | input | 1 | APM command strobe |
| apm_cmd | input | 8 | APM command value |
| gpe_hit | input | 1 | General-purpose event pending and enabled |
| sci | output | 1 | System control interrupt, level |
| poweroff_req | output | 1 | Soft power-off request pulse |
| reset_req | output | 1 | Reset request pulse |
| suspend_pulse | output | 1 | Suspend-to-RAM indication pulse |

## Verification
The risky collisions happen when an event source and a software clear hit the same status bit in one cycle. The sharpest case is the timer crossing its overflow point in the very cycle that software clears timer status and re-arms the point. The bench steers the tick count to the last value before the next boundary, then issues the clear together with a tick, and expects timer status to stay set. It also pairs a power-button event with a write-one-to-clear of that bit, and an APM command with a control write. A cycle-accurate model in the bench judges both the directed cases and several thousand random cycles in which such overlaps occur by chance.

// File: rtl/pm1_pkg.sv
package pm1_pkg;

   // register window
   localparam int WIN_BYTES = 64;
   localparam int ADDR_W    = $clog2(WIN_BYTES);
   localparam int REG_W     = 16;
   localparam int RD_W      = 32;

   localparam logic [ADDR_W-1:0] OFF_STS = ADDR_W'(8'h00);
   localparam logic [ADDR_W-1:0] OFF_EN  = ADDR_W'(8'h02);
   localparam logic [ADDR_W-1:0] OFF_CTL = ADDR_W'(8'h04);
   localparam logic [ADDR_W-1:0] OFF_TMR = ADDR_W'(8'h08);

   // status / enable bit positions
   localparam int B_TMR = 0;
   localparam int B_GBL = 5;
   localparam int B_PWR = 8;
   localparam int B_RTC = 10;
   localparam int B_WAK = 15;

   // control bit positions
   localparam int B_SCIEN  = 0;
   localparam int B_SLPEN  = 13;
   localparam int SLPTYP_LO = 10;
   localparam int SLPTYP_W  = 3;

   localparam logic [REG_W-1:0] SCI_SRC_MASK =
      REG_W'((1 << B_TMR) | (1 << B_GBL) | (1 << B_PWR) | (1 << B_RTC));
   localparam logic [REG_W-1:0] STS_IMPL =
      REG_W'((1 << B_TMR) | (1 << B_GBL) | (1 << B_PWR) | (1 << B_RTC) | (1 << B_WAK));

   localparam logic [SLPTYP_W-1:0] SLP_SOFT_OFF = 3'd0;
   localparam logic [SLPTYP_W-1:0] SLP_SUSPEND  = 3'd1;

   localparam logic [7:0] APM_SCI_ON  = 8'hF1;
   localparam logic [7:0] APM_SCI_OFF = 8'hF0;

   typedef struct packed {
      logic              vld;
      logic [ADDR_W-1:0] addr;
      logic [REG_W-1:0]  data;
   } reg_wr_t;

endpackage

// File: rtl/pm1_timer.sv
module pm1_timer #(
   parameter int CNT_W = 24
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_en,
   input  logic             rearm,
   output logic [CNT_W-1:0] count,
   output logic             ovf_hit
);

   localparam logic [CNT_W-1:0] HALF     = CNT_W'(1) << (CNT_W - 1);
   localparam logic [CNT_W-1:0] LOW_MASK = HALF - CNT_W'(1);

   generate
      if (CNT_W < 2) begin : g_bad_width
         $error("pm1_timer: CNT_W must be at least 2");
      end
   endgenerate

   logic [CNT_W-1:0] ovf_pt;
   logic [CNT_W-1:0] count_inc;
   logic [CNT_W-1:0] rearm_pt;
   logic [CNT_W-1:0] cmp_pt;

   assign count_inc = count + CNT_W'(1);
   // next half-range boundary strictly above the present count
   assign rearm_pt  = (count + HALF) & ~LOW_MASK;
   // a re-arm takes effect for the comparison of this same cycle
   assign cmp_pt    = rearm ? rearm_pt : ovf_pt;
   assign ovf_hit   = tick_en && (count_inc == cmp_pt);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count  <= '0;
         ovf_pt <= HALF;
      end else begin
         if (tick_en) count <= count_inc;
         if (rearm)   ovf_pt <= rearm_pt;
      end
   end

   // R1
   count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tick_en |=> count == $past(count) + CNT_W'(1));

   // R1
   count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !tick_en |=> $stable(count));

   // R2
   hit_on_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_hit |=> (count & LOW_MASK) == '0);

endmodule

// File: rtl/pm1_evt_regs.sv
module pm1_evt_regs
   import pm1_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  reg_wr_t          wr,
   input  logic             ovf_hit,
   input  logic             pwrbtn_evt,
   input  logic             sleep_wake,
   output logic             rearm,
   output logic [REG_W-1:0] sts_q,
   output logic [REG_W-1:0] en_q
);

   logic             wr_sts;
   logic             wr_en;
   logic [REG_W-1:0] clr_m;
   logic [REG_W-1:0] set_m;
   logic [REG_W-1:0] sts_nxt;
   logic             pwr_set;

   assign wr_sts  = wr.vld && (wr.addr == OFF_STS);
   assign wr_en   = wr.vld && (wr.addr == OFF_EN);
   assign clr_m   = wr_sts ? wr.data : '0;
   assign rearm   = wr_sts && wr.data[B_TMR] && sts_q[B_TMR];
   assign pwr_set = (pwrbtn_evt && en_q[B_PWR]) || sleep_wake;

   always_comb begin
      set_m        = '0;
      set_m[B_TMR] = ovf_hit;
      set_m[B_PWR] = pwr_set;
      set_m[B_WAK] = sleep_wake;
   end

   // set beats clear so that no event is lost
   assign sts_nxt = ((sts_q & ~clr_m) | set_m) & STS_IMPL;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sts_q <= '0;
         en_q  <= '0;
      end else begin
         sts_q <= sts_nxt;
         if (wr_en) en_q <= wr.data;
      end
   end

   // R11
   pwr_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pwrbtn_evt && !en_q[B_PWR] && !sleep_wake) |=>
         (sts_q[B_PWR] == ($past(sts_q[B_PWR]) && !$past(clr_m[B_PWR]))));

   // R3
   wake_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_sts && wr.data[B_WAK] && !sleep_wake) |=> !sts_q[B_WAK]);

   // R3
   zero_write_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_sts && !wr.data[B_PWR] && sts_q[B_PWR]) |=> sts_q[B_PWR]);

endmodule

// File: rtl/pm1_ctl.sv
module pm1_ctl
   import pm1_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  reg_wr_t          wr,
   input  logic             apm_wr,
   input  logic [7:0]       apm_cmd,
   output logic [REG_W-1:0] ctl_q,
   output logic             sleep_wake,
   output logic             poweroff_req,
   output logic             reset_req,
   output logic             suspend_pulse
);

   logic                wr_ctl;
   logic                slp_go;
   logic [SLPTYP_W-1:0] slp_typ;
   logic                go_off;
   logic [REG_W-1:0]    ctl_nxt;

   assign wr_ctl     = wr.vld && (wr.addr == OFF_CTL);
   assign slp_go     = wr_ctl && wr.data[B_SLPEN];
   assign slp_typ    = wr.data[SLPTYP_LO +: SLPTYP_W];
   assign go_off     = slp_go && (slp_typ == SLP_SOFT_OFF);
   assign sleep_wake = slp_go && (slp_typ == SLP_SUSPEND);

   always_comb begin
      ctl_nxt = ctl_q;
      if (wr_ctl) begin
         ctl_nxt          = wr.data;
         ctl_nxt[B_SLPEN] = 1'b0;
      end
      // firmware command overrides the write for the SCI-enable bit
      if (apm_wr && (apm_cmd == APM_SCI_ON))  ctl_nxt[B_SCIEN] = 1'b1;
      if (apm_wr && (apm_cmd == APM_SCI_OFF)) ctl_nxt[B_SCIEN] = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_q         <= '0;
         poweroff_req  <= 1'b0;
         reset_req     <= 1'b0;
         suspend_pulse <= 1'b0;
      end else begin
         ctl_q         <= ctl_nxt;
         poweroff_req  <= go_off;
         reset_req     <= sleep_wake;
         suspend_pulse <= sleep_wake;
      end
   end

   // R10
   apm_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (apm_wr && apm_cmd == APM_SCI_ON) |=> ctl_q[B_SCIEN]);

   // R10
   apm_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (apm_wr && apm_cmd == APM_SCI_OFF) |=> !ctl_q[B_SCIEN]);

   // R7
   soft_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (slp_go && slp_typ == SLP_SOFT_OFF) |=> poweroff_req);

   // R8
   other_type_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!slp_go) |=> (!poweroff_req && !reset_req && !suspend_pulse));

endmodule

// File: rtl/pm1_block.sv
module pm1_block
   import pm1_pkg::*;
#(
   parameter int CNT_W = 24
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_en,
   input  logic              reg_wr,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [REG_W-1:0]  reg_wdata,
   output logic [RD_W-1:0]   reg_rdata,
   input  logic              pwrbtn_evt,
   input  logic              apm_wr,
   input  logic [7:0]        apm_cmd,
   input  logic              gpe_hit,
   output logic              sci,
   output logic              poweroff_req,
   output logic              reset_req,
   output logic              suspend_pulse
);

   generate
      if (CNT_W < 2 || CNT_W > RD_W) begin : g_bad_cnt
         $error("pm1_block: CNT_W must lie between 2 and the read width");
      end
   endgenerate

   reg_wr_t          wr;
   logic [CNT_W-1:0] tmr_count;
   logic             ovf_hit;
   logic             rearm;
   logic             sleep_wake;
   logic [REG_W-1:0] sts_q;
   logic [REG_W-1:0] en_q;
   logic [REG_W-1:0] ctl_q;
   logic             pm_pend;

   assign wr.vld  = reg_wr;
   assign wr.addr = reg_addr;
   assign wr.data = reg_wdata;

   pm1_timer #(.CNT_W(CNT_W)) u_tmr (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick_en (tick_en),
      .rearm   (rearm),
      .count   (tmr_count),
      .ovf_hit (ovf_hit)
   );

   pm1_evt_regs u_evt (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr         (wr),
      .ovf_hit    (ovf_hit),
      .pwrbtn_evt (pwrbtn_evt),
      .sleep_wake (sleep_wake),
      .rearm      (rearm),
      .sts_q      (sts_q),
      .en_q       (en_q)
   );

   pm1_ctl u_ctl (
      .clk           (clk),
      .rst_n         (rst_n),
      .wr            (wr),
      .apm_wr        (apm_wr),
      .apm_cmd       (apm_cmd),
      .ctl_q         (ctl_q),
      .sleep_wake    (sleep_wake),
      .poweroff_req  (poweroff_req),
      .reset_req     (reset_req),
      .suspend_pulse (suspend_pulse)
   );

   assign pm_pend = |(sts_q & en_q & SCI_SRC_MASK);
   assign sci     = pm_pend || gpe_hit;

   always_comb begin
      case (reg_addr)
         OFF_STS: reg_rdata = RD_W'(sts_q);
         OFF_EN:  reg_rdata = RD_W'(en_q);
         OFF_CTL: reg_rdata = RD_W'(ctl_q);
         OFF_TMR: reg_rdata = RD_W'(tmr_count);
         default: reg_rdata = '0;
      endcase
   end

   // R4
   sci_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!gpe_hit && ((sts_q & en_q) == '0)) |-> !sci);

   // R8
   suspend_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
      reset_req |-> (suspend_pulse && !poweroff_req));

   // R8
   wake_marked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      reset_req |-> (sts_q[B_WAK] && sts_q[B_PWR]));

   // R6
   slpen_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == OFF_CTL) |=> !reg_rdata[B_SLPEN] || reg_addr != OFF_CTL);

endmodule

// File: tb/pm1_block_test.sv
module pm1_block_test;
   import pm1_pkg::*;

   localparam int TB_CNT_W   = 12;
   localparam int CLK_PERIOD = 10;
   localparam int HALF       = 1 << (TB_CNT_W - 1);
   localparam int CMASK      = (1 << TB_CNT_W) - 1;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick_en = 1'b0;
   logic        reg_wr = 1'b0;
   logic [5:0]  reg_addr = '0;
   logic [15:0] reg_wdata = '0;
   logic        pwrbtn_evt = 1'b0;
   logic        apm_wr = 1'b0;
   logic [7:0]  apm_cmd = '0;
   logic        gpe_hit = 1'b0;
   logic [31:0] reg_rdata;
   logic        sci, poweroff_req, reset_req, suspend_pulse;

   int n_chk = 0;
   int n_fail = 0;

   // reference model state
   int          m_cnt, m_ovf;
   logic [15:0] m_sts, m_en, m_ctl;
   logic        m_poff, m_rst, m_s3;

   always #(CLK_PERIOD / 2) clk = ~clk;

   pm1_block #(.CNT_W(TB_CNT_W)) uut (
      .clk (clk), .rst_n (rst_n), .tick_en (tick_en),
      .reg_wr (reg_wr), .reg_addr (reg_addr), .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata), .pwrbtn_evt (pwrbtn_evt),
      .apm_wr (apm_wr), .apm_cmd (apm_cmd), .gpe_hit (gpe_hit),
      .sci (sci), .poweroff_req (poweroff_req), .reset_req (reset_req),
      .suspend_pulse (suspend_pulse)
   );

   task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got 0x%0h expected 0x%0h at %0t", req, got, exp, $time);
      end
   endtask

   function automatic logic [31:0] exp_rd(input logic [5:0] a);
      case (a)
         6'h00:   return {16'h0, m_sts};
         6'h02:   return {16'h0, m_en};
         6'h04:   return {16'h0, m_ctl};
         6'h08:   return 32'(m_cnt);
         default: return 32'h0;
      endcase
   endfunction

   function automatic string rd_req(input logic [5:0] a);
      case (a)
         6'h00:   return "R3";
         6'h02:   return "R5";
         6'h04:   return "R6";
         6'h08:   return "R1";
         default: return "R9";
      endcase
   endfunction

   function automatic logic exp_sci();
      return ((m_sts & m_en & 16'h0521) != 16'h0) || gpe_hit;
   endfunction

   task automatic model_reset();
      m_cnt = 0; m_ovf = HALF;
      m_sts = '0; m_en = '0; m_ctl = '0;
      m_poff = 1'b0; m_rst = 1'b0; m_s3 = 1'b0;
   endtask

   task automatic model_step();
      logic        wr_sts, rearm, hit, slp_go, wake;
      logic [2:0]  typ;
      logic [15:0] set_m, clr_m;
      int          rpt, cmp, inc;
      wr_sts = reg_wr && (reg_addr == 6'h00);
      rearm  = wr_sts && reg_wdata[0] && m_sts[0];
      rpt    = ((m_cnt + HALF) & ~(HALF - 1)) & CMASK;
      cmp    = rearm ? rpt : m_ovf;
      inc    = (m_cnt + 1) & CMASK;
      hit    = tick_en && (inc == cmp);
      slp_go = reg_wr && (reg_addr == 6'h04) && reg_wdata[13];
      typ    = reg_wdata[12:10];
      wake   = slp_go && (typ == 3'd1);
      set_m  = '0;
      set_m[0]  = hit;
      set_m[8]  = (pwrbtn_evt && m_en[8]) || wake;
      set_m[15] = wake;
      clr_m  = wr_sts ? reg_wdata : 16'h0;
      m_sts  = (m_sts & ~clr_m) | set_m;
      if (reg_wr && reg_addr == 6'h02) m_en = reg_wdata;
      if (reg_wr && reg_addr == 6'h04) m_ctl = reg_wdata & 16'hDFFF;
      if (apm_wr && apm_cmd == 8'hF1) m_ctl[0] = 1'b1;
      if (apm_wr && apm_cmd == 8'hF0) m_ctl[0] = 1'b0;
      m_poff = slp_go && (typ == 3'd0);
      m_rst  = wake;
      m_s3   = wake;
      if (tick_en) m_cnt = inc;
      if (rearm)   m_ovf = rpt;
   endtask

   // one clock: called just after a falling edge with inputs driven
   task automatic run_cycle(input string xreq = "", input logic [31:0] xexp = 32'h0);
      #1;
      if (xreq != "") chk(xreq, reg_rdata, xexp);
      chk(rd_req(reg_addr), reg_rdata, exp_rd(reg_addr));
      chk("R4", {31'h0, sci}, {31'h0, exp_sci()});
      @(posedge clk);
      model_step();
      @(negedge clk);
      chk("R7", {31'h0, poweroff_req}, {31'h0, m_poff});
      chk("R8", {31'h0, reset_req}, {31'h0, m_rst});
      chk("R8", {31'h0, suspend_pulse}, {31'h0, m_s3});
   endtask

   task automatic peek(input logic [5:0] a, input string req, input logic [31:0] e);
      reg_addr = a;
      run_cycle(req, e);
   endtask

   task automatic wr_reg(input logic [5:0] a, input logic [15:0] d);
      reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
      run_cycle();
      reg_wr = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      void'($urandom(32'h5eed_0042));
      model_reset();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R12 reset state
      peek(6'h00, "R12", 32'h0);
      peek(6'h02, "R12", 32'h0);
      peek(6'h04, "R12", 32'h0);
      peek(6'h08, "R12", 32'h0);
      chk("R12", {31'h0, sci}, 32'h0);

      // R5 enable store
      wr_reg(6'h02, 16'hA5C3);
      peek(6'h02, "R5", 32'h0000A5C3);

      // R11 power button gated by enable
      wr_reg(6'h02, 16'h0000);
      pwrbtn_evt = 1'b1; run_cycle(); pwrbtn_evt = 1'b0;
      peek(6'h00, "R11", 32'h0);
      wr_reg(6'h02, 16'h0100);
      pwrbtn_evt = 1'b1; run_cycle(); pwrbtn_evt = 1'b0;
      peek(6'h00, "R11", 32'h0100);
      chk("R4", {31'h0, sci}, 32'h1);

      // R3 set wins over same-cycle clear, zero write keeps, one write clears
      reg_addr = 6'h00; reg_wdata = 16'h0100; reg_wr = 1'b1; pwrbtn_evt = 1'b1;
      run_cycle();
      reg_wr = 1'b0; pwrbtn_evt = 1'b0;
      peek(6'h00, "R3", 32'h0100);
      wr_reg(6'h00, 16'h0000);
      peek(6'h00, "R3", 32'h0100);
      wr_reg(6'h00, 16'h0100);
      peek(6'h00, "R3", 32'h0);

      // R10 APM command
      apm_wr = 1'b1; apm_cmd = 8'hF1; run_cycle(); apm_wr = 1'b0;
      peek(6'h04, "R10", 32'h1);
      apm_wr = 1'b1; apm_cmd = 8'h55; run_cycle(); apm_wr = 1'b0;
      peek(6'h04, "R10", 32'h1);
      apm_wr = 1'b1; apm_cmd = 8'hF0; run_cycle(); apm_wr = 1'b0;
      peek(6'h04, "R10", 32'h0);
      reg_addr = 6'h04; reg_wdata = 16'h0000; reg_wr = 1'b1;
      apm_wr = 1'b1; apm_cmd = 8'hF1;
      run_cycle();
      reg_wr = 1'b0; apm_wr = 1'b0;
      peek(6'h04, "R10", 32'h1);

      // R6 sleep enable not stored; type 7 does nothing
      wr_reg(6'h04, 16'hFFFF);
      chk("R8", {29'h0, poweroff_req, reset_req, suspend_pulse}, 32'h0);
      peek(6'h04, "R6", 32'h0000DFFF);

      // R7 soft power-off pulse
      wr_reg(6'h04, 16'h2000);
      chk("R7", {31'h0, poweroff_req}, 32'h1);
      run_cycle();
      chk("R7", {31'h0, poweroff_req}, 32'h0);

      // R8 suspend: reset, indication, wake and power-button status
      wr_reg(6'h04, 16'h2400);
      chk("R8", {29'h0, poweroff_req, reset_req, suspend_pulse}, 32'h3);
      peek(6'h00, "R8", 32'h8100);

      // R9 unmapped offsets
      peek(6'h06, "R9", 32'h0);
      peek(6'h0A, "R9", 32'h0);
      peek(6'h3E, "R9", 32'h0);
      wr_reg(6'h08, 16'h1234);
      wr_reg(6'h06, 16'hFFFF);
      peek(6'h08, "R9", 32'h0);
      peek(6'h02, "R9", 32'h0100);

      // R2 overflow, clear colliding with boundary crossing, re-arm
      wr_reg(6'h00, 16'hFFFF);
      wr_reg(6'h02, 16'h0001);
      tick_en = 1'b1;
      reg_addr = 6'h08;
      repeat (HALF - 1) run_cycle();
      peek(6'h08, "R1", 32'(HALF - 1));
      peek(6'h00, "R2", 32'h1);
      reg_addr = 6'h08;
      repeat (CMASK - HALF - 1) run_cycle();
      peek(6'h08, "R1", 32'(CMASK));
      // count now wrapped to 0 and status still set; go back to CMASK-equivalent case
      // count is 0: advance to last value before the next boundary (HALF-1)
      repeat (HALF - 1) run_cycle();
      // count == HALF-1 with status set: clear plus tick lands on new point
      wr_reg(6'h00, 16'h0001);
      peek(6'h00, "R2", 32'h1);
      wr_reg(6'h00, 16'h0001);
      peek(6'h00, "R2", 32'h0);
      peek(6'h08, "R1", 32'(HALF + 3));
      tick_en = 1'b0;

      // random traffic
      for (int i = 0; i < 4000; i++) begin
         tick_en    = ($urandom % 2) == 0;
         pwrbtn_evt = ($urandom % 12) == 0;
         gpe_hit    = ($urandom % 8) == 0;
         apm_wr     = ($urandom % 10) == 0;
         case ($urandom % 3)
            0: apm_cmd = 8'hF0;
            1: apm_cmd = 8'hF1;
            default: apm_cmd = 8'($urandom);
         endcase
         reg_wr = ($urandom % 4) == 0;
         case ($urandom % 6)
            0: reg_addr = 6'h00;
            1: reg_addr = 6'h02;
            2: reg_addr = 6'h04;
            3: reg_addr = 6'h08;
            4: reg_addr = 6'h06;
            default: reg_addr = 6'($urandom);
         endcase
         reg_wdata = 16'($urandom);
         if (reg_addr == 6'h04) reg_wdata[13] = ($urandom % 4) == 0;
         run_cycle();
      end
      reg_wr = 1'b0; apm_wr = 1'b0; pwrbtn_evt = 1'b0; gpe_hit = 1'b0; tick_en = 1'b0;
      run_cycle();

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule